// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

The block sits between a processor port and a word-addressed main-memory port. Each processor request carries a 32-bit byte address. The controller splits that address into a tag, a line index and a word offset. It then looks up a single candidate line, which it accepts only when the line's valid flag is set and its stored tag equals the request tag. A hit completes in the same cycle it is presented. A miss holds the processor while the whole line is fetched from memory one word at a time. The controller then records the new tag, marks the line valid and completes the access from the refilled line.

Stores use a write-through policy. The addressed word in the line is updated, and an address/data pair is posted into a small FIFO. The FIFO empties toward memory in the background, so a store stalls the processor only when the FIFO is full. A store that misses first refills its line and then merges its word into it. Before any refill reads memory, every posted store must have drained, so a refill can never return data older than a store the processor has already completed. Two free-running counters report completed hits and completed misses.

Top module: `dmwt_cache`

## Requirements
- R1: Reset is synchronous and active high. After reset every line is invalid, `cpu_done` and `mem_req` are low, both counters read zero, and the first access to any address is a miss.
- R2: With the default 256 lines of 4 words, address bits [3:2] select the word, bits [11:4] select the line and bits [31:12] form the tag. Bits [1:0] are ignored, and every access moves a whole 32-bit word.
- R3: A read whose line is valid with a matching tag raises `cpu_done` in the cycle the request is presented and returns the stored word on `cpu_rdata`.
- R4: A read miss holds `cpu_done` low. It then issues one memory read per word of the line at word addresses {tag, index, k}, for k from 0 up to WORDS-1 in increasing order. Only after that does it complete with the requested word.
- R5: Two addresses that share a line index but differ in tag evict each other. Reads at 0x14, 0x1C, 0x34 and 0x8014 from reset give miss, hit, miss, miss.
- R6: A store that hits while the post buffer has a free slot completes in the cycle it is presented. A later read of that address returns the stored data.
- R7: Every completed store appears on the memory port as one write of its word address and data, in program order. Once the buffer has emptied, main memory holds the last stored value of every address.
- R8: A store that misses refills its whole line first and then writes its word. Other words of that line keep their memory values, and the access is counted as a miss.
- R9: The post buffer holds POST_DEPTH (default 4) pending stores. A store presented while all slots are pending stalls until one slot drains.
- R10: A refill issues no memory read until every posted store has been accepted by memory. A read after a conflicting eviction therefore returns the latest stored data.
- R11: `hit_count` increments once for each access that completes without a refill. `miss_count` increments once for each access that needs a refill.
- R12: `mem_req` together with `mem_we`, `mem_addr` and `mem_wdata` stays unchanged until a cycle with `mem_ready` high. In that cycle a write is accepted, or read data is taken from `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| cpu_done | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write (posted store), 0 = refill read |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts / answers the request this cycle |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Completed misses |

## Verification
The bench targets conflict eviction on a shared index. A controller that compares only part of the tag would report a hit there and return the wrong line's word. It also fills the post buffer while memory withholds ready: a design that drops or overwrites a slot loses a store, which shows up when final memory contents are compared. A read miss is issued while stores are still posted, and any refill read granted with writes outstanding is flagged, because it could return stale data. Refill beat order, the stability of held memory requests and a store-miss merge that must keep neighbouring words are each checked against a behavioural memory and tag model.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int BYTE_LG = 2;
    localparam int WADDR_W = ADDR_W - BYTE_LG;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [WADDR_W-1:0] waddr_t;

    typedef enum logic [1:0] {
        CS_LOOK  = 2'd0,
        CS_DRAIN = 2'd1,
        CS_FILL  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        waddr_t waddr;
        word_t  data;
    } post_entry_t;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store
    import dmc_pkg::*;
#(
    parameter  int LINES  = 256,
    parameter  int WORDS  = 4,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WOFF_W = $clog2(WORDS),
    localparam int TAG_W  = WADDR_W - IDX_W - WOFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [WOFF_W-1:0] lk_woff,
    output logic              lk_hit,
    output word_t             lk_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WOFF_W-1:0] wr_woff,
    input  word_t             wr_data,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  set_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    word_t            data_q [LINES*WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (set_en) begin
            valid_q[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[set_idx] <= set_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[{wr_idx, wr_woff}] <= wr_data;
        end
    end

    assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_word = data_q[{lk_idx, lk_woff}];
endmodule

// File: rtl/dmc_post_buf.sv
module dmc_post_buf
    import dmc_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  post_entry_t push_ent,
    input  logic        pop,
    output post_entry_t head,
    output logic        nonempty,
    output logic        full
);
    post_entry_t      slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [OCC_W-1:0] occ_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wr_ptr_q == PTR_W'(g))) begin
                slot_q[g] <= push_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({push, pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    assign head     = slot_q[rd_ptr_q];
    assign nonempty = (occ_q != '0);
    assign full     = (occ_q == OCC_W'(DEPTH));

    // R9: the controller never posts into a buffer with no free slot
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> !full);

    // R7: memory only drains entries that were posted
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> nonempty);
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter  int LINES  = 256,
    parameter  int WORDS  = 4,
    parameter  int CNT_W  = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WOFF_W = $clog2(WORDS),
    localparam int TAG_W  = WADDR_W - IDX_W - WOFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  word_t             cpu_wdata,
    output logic              cpu_done,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [WOFF_W-1:0] lk_woff,
    input  logic              lk_hit,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WOFF_W-1:0] wr_woff,
    output word_t             wr_data,
    output logic              set_en,
    output logic [IDX_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  set_tag,
    input  logic              wb_full,
    input  logic              wb_nonempty,
    output logic              wb_push,
    output post_entry_t       wb_ent,
    output logic              fill_req,
    output waddr_t            fill_waddr,
    input  logic              mem_ready,
    input  word_t             mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(WORDS - 1);

    ctl_state_e        state_q;
    logic [TAG_W-1:0]  fill_tag_q;
    logic [IDX_W-1:0]  fill_idx_q;
    logic [WOFF_W-1:0] fill_cnt_q;
    logic              after_fill_q;
    logic [CNT_W-1:0]  hit_q;
    logic [CNT_W-1:0]  miss_q;
    logic              fill_beat;
    logic              store_done;
    logic              unused_bytes;

    assign unused_bytes = ^cpu_addr[BYTE_LG-1:0];

    // address split: byte bits dropped, then word offset, index, tag
    assign lk_woff = cpu_addr[BYTE_LG +: WOFF_W];
    assign lk_idx  = cpu_addr[BYTE_LG + WOFF_W +: IDX_W];
    assign lk_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

    always_comb begin
        cpu_done   = (state_q == CS_LOOK) && cpu_req && lk_hit && (!cpu_we || !wb_full);
        store_done = cpu_done && cpu_we;
        fill_beat  = (state_q == CS_FILL) && mem_ready;

        wr_en   = store_done || fill_beat;
        wr_idx  = fill_beat ? fill_idx_q : lk_idx;
        wr_woff = fill_beat ? fill_cnt_q : lk_woff;
        wr_data = fill_beat ? mem_rdata  : cpu_wdata;

        set_en  = fill_beat && (fill_cnt_q == LAST_BEAT);
        set_idx = fill_idx_q;
        set_tag = fill_tag_q;

        wb_push      = store_done;
        wb_ent.waddr = cpu_addr[ADDR_W-1:BYTE_LG];
        wb_ent.data  = cpu_wdata;

        fill_req   = (state_q == CS_FILL);
        fill_waddr = {fill_tag_q, fill_idx_q, fill_cnt_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= CS_LOOK;
            fill_tag_q   <= '0;
            fill_idx_q   <= '0;
            fill_cnt_q   <= '0;
            after_fill_q <= 1'b0;
            hit_q        <= '0;
            miss_q       <= '0;
        end else begin
            case (state_q)
                CS_LOOK: begin
                    if (cpu_req && !lk_hit) begin
                        fill_tag_q <= lk_tag;
                        fill_idx_q <= lk_idx;
                        miss_q     <= miss_q + 1'b1;
                        state_q    <= CS_DRAIN;
                    end
                end
                CS_DRAIN: begin
                    if (!wb_nonempty) begin
                        fill_cnt_q <= '0;
                        state_q    <= CS_FILL;
                    end
                end
                CS_FILL: begin
                    if (mem_ready) begin
                        fill_cnt_q <= fill_cnt_q + 1'b1;
                        if (fill_cnt_q == LAST_BEAT) begin
                            after_fill_q <= 1'b1;
                            state_q      <= CS_LOOK;
                        end
                    end
                end
                default: state_q <= CS_LOOK;
            endcase
            if (cpu_done) begin
                after_fill_q <= 1'b0;
                if (!after_fill_q) begin
                    hit_q <= hit_q + 1'b1;
                end
            end
        end
    end

    assign hit_count  = hit_q;
    assign miss_count = miss_q;

    // R10: no refill beat while a posted store is still pending
    p_fill_after_drain_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_FILL) |-> !wb_nonempty);

    // R4: refill beats advance one word at a time, lowest first
    p_fill_order_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_beat && (fill_cnt_q != LAST_BEAT)) |=>
            ((state_q == CS_FILL) && (fill_cnt_q == $past(fill_cnt_q) + 1'b1)));

    // R4: a completed refill makes the held request hit in the line store
    p_hit_after_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_beat && (fill_cnt_q == LAST_BEAT) && cpu_req) |=> lk_hit);

    // R11: the miss counter moves by at most one per cycle
    p_miss_step_r11: assert property (@(posedge clk) disable iff (rst)
        (miss_q != $past(miss_q)) |-> (miss_q == $past(miss_q) + 1'b1));
endmodule

// File: rtl/dmwt_cache.sv
module dmwt_cache
    import dmc_pkg::*;
#(
    parameter int LINES      = 256,
    parameter int WORDS      = 4,
    parameter int POST_DEPTH = 4,
    parameter int CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [31:0]      cpu_addr,
    input  logic [31:0]      cpu_wdata,
    output logic [31:0]      cpu_rdata,
    output logic             cpu_done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [29:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ready,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int WOFF_W = $clog2(WORDS);
    localparam int TAG_W  = WADDR_W - IDX_W - WOFF_W;

    logic [TAG_W-1:0]  lk_tag;
    logic [IDX_W-1:0]  lk_idx;
    logic [WOFF_W-1:0] lk_woff;
    logic              lk_hit;
    word_t             lk_word;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WOFF_W-1:0] wr_woff;
    word_t             wr_data;
    logic              set_en;
    logic [IDX_W-1:0]  set_idx;
    logic [TAG_W-1:0]  set_tag;
    logic              wb_push;
    logic              wb_pop;
    post_entry_t       wb_ent;
    post_entry_t       wb_head;
    logic              wb_nonempty;
    logic              wb_full;
    logic              fill_req;
    waddr_t            fill_waddr;

    dmc_ctrl #(.LINES(LINES), .WORDS(WORDS), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_done   (cpu_done),
        .lk_tag     (lk_tag),
        .lk_idx     (lk_idx),
        .lk_woff    (lk_woff),
        .lk_hit     (lk_hit),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_woff    (wr_woff),
        .wr_data    (wr_data),
        .set_en     (set_en),
        .set_idx    (set_idx),
        .set_tag    (set_tag),
        .wb_full    (wb_full),
        .wb_nonempty(wb_nonempty),
        .wb_push    (wb_push),
        .wb_ent     (wb_ent),
        .fill_req   (fill_req),
        .fill_waddr (fill_waddr),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    dmc_line_store #(.LINES(LINES), .WORDS(WORDS)) u_store (
        .clk    (clk),
        .rst    (rst),
        .lk_tag (lk_tag),
        .lk_idx (lk_idx),
        .lk_woff(lk_woff),
        .lk_hit (lk_hit),
        .lk_word(lk_word),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_woff(wr_woff),
        .wr_data(wr_data),
        .set_en (set_en),
        .set_idx(set_idx),
        .set_tag(set_tag)
    );

    dmc_post_buf #(.DEPTH(POST_DEPTH)) u_post (
        .clk     (clk),
        .rst     (rst),
        .push    (wb_push),
        .push_ent(wb_ent),
        .pop     (wb_pop),
        .head    (wb_head),
        .nonempty(wb_nonempty),
        .full    (wb_full)
    );

    // memory port: the refill owns it while active, otherwise the buffer drains
    assign mem_req   = fill_req || wb_nonempty;
    assign mem_we    = !fill_req;
    assign mem_addr  = fill_req ? fill_waddr : wb_head.waddr;
    assign mem_wdata = wb_head.data;
    assign wb_pop    = !fill_req && wb_nonempty && mem_ready;
    assign cpu_rdata = lk_word;

    // R12: a waiting memory request holds its command until accepted
    p_mem_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/dmwt_cache_tb_top.sv
module dmwt_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LINES_TB   = 256;
    localparam int WORDS_TB   = 4;

    logic        clk;
    logic        rst;
    logic        cpu_req;
    logic        cpu_we;
    logic [31:0] cpu_addr;
    logic [31:0] cpu_wdata;
    logic [31:0] cpu_rdata;
    logic        cpu_done;
    logic        mem_req;
    logic        mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ready;
    logic [31:0] hit_count;
    logic [31:0] miss_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] bmem [int unsigned];
    logic [31:0] refm [int unsigned];
    int unsigned mtag [int unsigned];
    int exp_hits = 0;
    int exp_miss = 0;
    int pend_wr = 0;
    int nstores = 0;
    int nwrites = 0;
    int mem_lat = 0;
    bit mem_hold = 0;

    dmwt_cache dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .hit_count(hit_count),
        .miss_count(miss_count)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] init_word(int unsigned wa);
        return (wa * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder with variable latency; also watches port discipline
    initial begin
        int lat_cnt = 0;
        bit waiting = 0;
        logic [29:0] w_addr = '0;
        logic w_we = 1'b0;
        int unsigned last_rd = 0;
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (waiting) begin
                chk(mem_req && mem_addr == w_addr && mem_we == w_we, "R12",
                    "held request changed", {2'b0, mem_addr}, {2'b0, w_addr});
            end
            if (mem_req && !rst) begin
                if (!mem_hold && lat_cnt >= mem_lat) begin
                    mem_ready = 1'b1;
                    lat_cnt = 0;
                    waiting = 0;
                    if (mem_we) begin
                        bmem[int'(mem_addr)] = mem_wdata;
                        pend_wr--;
                        nwrites++;
                    end else begin
                        mem_rdata = bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)]
                                                               : init_word(int'(mem_addr));
                        chk(pend_wr == 0, "R10", "refill read with stores pending",
                            pend_wr, 0);
                        if ((mem_addr % WORDS_TB) != 0) begin
                            chk(int'(mem_addr) == last_rd + 1, "R4", "refill beat order",
                                {2'b0, mem_addr}, last_rd + 1);
                        end
                        last_rd = int'(mem_addr);
                    end
                end else begin
                    mem_ready = 1'b0;
                    lat_cnt++;
                    waiting = 1;
                    w_addr = mem_addr;
                    w_we = mem_we;
                end
            end else begin
                mem_ready = 1'b0;
                lat_cnt = 0;
                waiting = 0;
            end
        end
    end

    // one processor access with reference prediction; called at a negedge
    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          input string req, output int cyc);
        int unsigned wa;
        int unsigned idx;
        int unsigned tag;
        bit exp_hit;
        logic [31:0] exp_rd;
        logic [31:0] got;
        wa  = addr[31:2];
        idx = (wa / WORDS_TB) % LINES_TB;
        tag = wa / (WORDS_TB * LINES_TB);
        exp_hit = mtag.exists(idx) && mtag[idx] == tag;
        if (exp_hit) exp_hits++;
        else begin
            exp_miss++;
            mtag[idx] = tag;
        end
        exp_rd = refm.exists(wa) ? refm[wa] : init_word(wa);
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = addr;
        cpu_wdata = wd;
        cyc = 0;
        forever begin
            #1;
            if (cpu_done) break;
            @(negedge clk);
            cyc++;
            if (cyc > 3000) break;
        end
        got = cpu_rdata;
        if (we) begin
            refm[wa] = wd;
            pend_wr++;
            nstores++;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        if (!we) chk(got == exp_rd, req, "read data", got, exp_rd);
        chk(hit_count == exp_hits, "R11", "hit count", hit_count, exp_hits);
        chk(miss_count == exp_miss, "R11", "miss count", miss_count, exp_miss);
        if (!exp_hit) chk(cyc > 0, "R4", "miss did not stall", cyc, 1);
        else if (!we) chk(cyc == 0, "R3", "read hit stalled", cyc, 0);
    endtask

    task automatic wait_drain();
        int n = 0;
        while (pend_wr != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c;
        logic [31:0] lf;
        rst = 1'b1;
        cpu_req = 1'b0;
        cpu_we = 1'b0;
        cpu_addr = '0;
        cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: idle state after reset
        chk(!cpu_done, "R1", "done after reset", cpu_done, 0);
        chk(!mem_req, "R1", "mem_req after reset", mem_req, 0);
        chk(hit_count == 0 && miss_count == 0, "R1", "counters after reset",
            hit_count + miss_count, 0);
        @(negedge clk);

        // R5: conflict sequence (also R1: first access misses)
        access(0, 32'h14, 0, "R5", c);
        chk(miss_count == 1, "R1", "first access not a miss", miss_count, 1);
        access(0, 32'h1C, 0, "R5", c);
        chk(c == 0, "R3", "0x1C should hit", c, 0);
        access(0, 32'h34, 0, "R5", c);
        access(0, 32'h8014, 0, "R5", c);
        chk(miss_count == 3 && hit_count == 1, "R5", "miss/hit split",
            {miss_count[15:0], hit_count[15:0]}, 32'h0003_0001);

        // R2: byte bits ignored; same word hits
        access(0, 32'h8017, 0, "R2", c);
        chk(c == 0, "R2", "byte-offset alias should hit", c, 0);

        // R6: store hit completes at once and reads back
        access(1, 32'h8018, 32'hCAFE_0001, "R6", c);
        chk(c == 0, "R6", "store hit stalled", c, 0);
        access(0, 32'h8018, 0, "R6", c);

        // R8: store miss refills then merges
        access(1, 32'h1000C, 32'hBEEF_0002, "R8", c);
        chk(c > 0, "R8", "store miss did not refill", c, 1);
        access(0, 32'h10008, 0, "R8", c);
        access(0, 32'h1000C, 0, "R8", c);

        // R9: buffer fills while memory withholds ready
        wait_drain();
        mem_hold = 1;
        for (int k = 0; k < 4; k++) begin
            access(1, 32'h10000 + 32'(k * 4), 32'hA000_0000 + 32'(k), "R9", c);
            chk(c == 0, "R9", "store into free slot stalled", c, 0);
        end
        fork
            begin
                repeat (12) @(negedge clk);
                mem_hold = 0;
            end
        join_none
        access(1, 32'h10004, 32'hA000_00FF, "R9", c);
        chk(c >= 10, "R9", "store into full buffer did not stall", c, 10);

        // R10: read miss while stores are posted
        wait_drain();
        mem_lat = 4;
        access(0, 32'h20000, 0, "R10", c);
        for (int k = 0; k < 4; k++) begin
            access(1, 32'h20000 + 32'(k * 4), 32'hD000_0000 + 32'(k), "R10", c);
        end
        access(0, 32'h30000, 0, "R10", c);
        access(0, 32'h2000C, 0, "R10", c);

        // mixed traffic over a small conflicting address set
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            mem_lat = int'(lf[9:8]) % 3;
            access(lf[3:0] < 4'd5,
                   (32'(lf[13:12] % 2'd3) << 12) | (32'(lf[17:16]) << 4) | (32'(lf[21:20]) << 2),
                   lf ^ 32'h0F0F_0F0F, "R7", c);
        end

        // R7: memory matches every store after draining
        wait_drain();
        chk(nwrites == nstores, "R7", "memory write count", nwrites, nstores);
        foreach (refm[a]) begin
            chk(bmem.exists(a) && bmem[a] == refm[a], "R7", "memory content",
                bmem.exists(a) ? bmem[a] : 32'hXXXX_XXXX, refm[a]);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule